// File: doc/BRIEF.md
# IPL Source Selection Responder

This block sits in an I/O device on a processor I/O channel. It lets the device serve as the source of the initial program load. A static two-bit role input sets the device to one of three roles: primary source, alternate source, or no source. The block watches the outbound initiate-IPL tag, which is always listened to, together with the channel status bus. Status bus bit 0 names the primary source and bit 1 names the alternate source.

When a rising edge of initiate-IPL arrives with the bit for this device's role set, the block raises the inbound IPL tag. It then asks the cycle-steal engine to carry out the storage load, using a plain request/done handshake. The tag stays up until the engine reports completion. The block then drops the tag and goes back to idle.

The sequencer has four states, with these transitions:
- IDLE to ACK when a qualified edge arrives.
- ACK to LOADING always, after one cycle.
- LOADING to DONE when the done input is sampled high.
- DONE to IDLE always, after one cycle.

Reset is synchronous and active low, and it puts the sequencer in IDLE.

Top module: `ipl_source_responder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the sequencer enters IDLE, and both `ipl_tag` and `load_req` read 0 after that edge, whatever the other inputs are.
- R2: With `role_cfg` = 2'b01 (primary), a rising edge of `init_ipl` sampled in IDLE with `status_bus[0]` = 1 moves the block to ACK. After that clock edge, `ipl_tag` = 1 and `load_req` = 0.
- R3: With `role_cfg` = 2'b10 (alternate), a rising edge of `init_ipl` sampled in IDLE with `status_bus[1]` = 1 moves the block to ACK, with the same outputs as in R2.
- R4: A rising edge of `init_ipl` gives no response in three cases: when neither of the role's bits is set, when only the other role's bit is set, or when `role_cfg` = 2'b00. Status bits above bit 1 never affect selection.
- R5: `role_cfg` = 2'b11 is treated as no role, so no edge ever gives a response.
- R6: `ipl_tag` stays 1 through ACK and LOADING. It drops to 0 in the cycle after `load_done` is sampled high in LOADING (the DONE state).
- R7: `load_req` is 1 exactly in LOADING. LOADING is entered one cycle after ACK, whatever the inputs are. `load_req` is never 1 while `ipl_tag` is 0.
- R8: Rising edges of `init_ipl` that arrive during ACK or LOADING are ignored. After the load completes, none of them causes a new load.
- R9: Only a rising edge selects the block. If `init_ipl` is held high, including a level already present when reset is released, no further response occurs.
- R10: `load_done` has no effect outside LOADING. In IDLE it leaves the outputs low, and in ACK it does not shorten the LOADING step.
- R11: A rising edge sampled in DONE is ignored. The next rising edge sampled after the block returns to IDLE starts a new load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| role_cfg | input | 2 | Static role: 00 none, 01 primary, 10 alternate, 11 treated as none |
| init_ipl | input | 1 | Outbound initiate-IPL tag from the channel |
| status_bus | input | STATUS_W | Channel status bus; bit 0 selects primary, bit 1 selects alternate |
| load_done | input | 1 | Cycle-steal engine reports the storage load is finished |
| ipl_tag | output | 1 | Inbound IPL tag to the processor |
| load_req | output | 1 | Request to the cycle-steal engine to perform the load |

## Verification
The hardest case to reach is a second initiate edge that lands while a load is still running. It needs a qualified edge that starts a load, then a fall and a fresh rise of `init_ipl` while `load_done` is held low, so that the edge is seen only in LOADING. The bench drives that sequence for the primary role and keeps the initiate level high through completion. It then confirms that the tag stays low and no second load starts. A similar sequence raises the initiate edge during the single DONE cycle, which shows that only an edge seen in IDLE starts a new load.

// File: rtl/ipl_resp_pkg.sv
package ipl_resp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACK     = 2'd1,
        ST_LOADING = 2'd2,
        ST_DONE    = 2'd3
    } ipl_state_e;

    typedef enum logic [1:0] {
        ROLE_NONE      = 2'b00,
        ROLE_PRIMARY   = 2'b01,
        ROLE_ALTERNATE = 2'b10,
        ROLE_ILLEGAL   = 2'b11
    } ipl_role_e;

    // Status bus positions that name each role; the channel decodes these.
    localparam int unsigned PRI_SEL_BIT = 0;
    localparam int unsigned ALT_SEL_BIT = 1;

endpackage

// File: rtl/ipl_select_decode.sv
module ipl_select_decode
    import ipl_resp_pkg::*;
#(
    parameter int unsigned STATUS_W = 8
) (
    input  logic                clk,
    input  logic [1:0]          role_cfg,
    input  logic                init_ipl,
    input  logic [STATUS_W-1:0] status_bus,
    output logic                select_hit
);

    localparam int unsigned HI_BITS = STATUS_W - 2;

    ipl_role_e role_q;
    logic      init_prev;
    logic      init_rise;
    logic      role_bit;

    // The previous initiate level is tracked even during reset, so that a level
    // held across reset release does not look like a new edge.
    always_ff @(posedge clk) begin
        init_prev <= init_ipl;
    end

    assign role_q    = ipl_role_e'(role_cfg);
    assign init_rise = init_ipl & ~init_prev;

    always_comb begin
        unique case (role_q)
            ROLE_PRIMARY:   role_bit = status_bus[PRI_SEL_BIT];
            ROLE_ALTERNATE: role_bit = status_bus[ALT_SEL_BIT];
            ROLE_NONE:      role_bit = 1'b0;
            ROLE_ILLEGAL:   role_bit = 1'b0;
            default:        role_bit = 1'b0;
        endcase
    end

    assign select_hit = init_rise & role_bit;

    // Upper status bits carry other channel status and never take part in selection.
    generate
        if (HI_BITS > 0) begin : g_hi_bits
            logic unused_status_hi;
            assign unused_status_hi = ^status_bus[STATUS_W-1:2];
        end
    endgenerate

endmodule

// File: rtl/ipl_seq_fsm.sv
module ipl_seq_fsm
    import ipl_resp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic select_hit,
    input  logic load_done,
    output logic ipl_tag,
    output logic load_req
);

    ipl_state_e state_q;
    ipl_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (select_hit) state_d = ST_ACK;
            ST_ACK:     state_d = ST_LOADING;
            ST_LOADING: if (load_done) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        ipl_tag  = 1'b0;
        load_req = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ipl_tag  = 1'b0;
                load_req = 1'b0;
            end
            ST_ACK: begin
                ipl_tag  = 1'b1;
                load_req = 1'b0;
            end
            ST_LOADING: begin
                ipl_tag  = 1'b1;
                load_req = 1'b1;
            end
            ST_DONE: begin
                ipl_tag  = 1'b0;
                load_req = 1'b0;
            end
            default: begin
                ipl_tag  = 1'b0;
                load_req = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ipl_source_responder.sv
module ipl_source_responder
    import ipl_resp_pkg::*;
#(
    parameter int unsigned STATUS_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          role_cfg,
    input  logic                init_ipl,
    input  logic [STATUS_W-1:0] status_bus,
    input  logic                load_done,
    output logic                ipl_tag,
    output logic                load_req
);

    logic select_hit;

    ipl_select_decode #(
        .STATUS_W (STATUS_W)
    ) u_decode (
        .clk        (clk),
        .role_cfg   (role_cfg),
        .init_ipl   (init_ipl),
        .status_bus (status_bus),
        .select_hit (select_hit)
    );

    ipl_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .select_hit (select_hit),
        .load_done  (load_done),
        .ipl_tag    (ipl_tag),
        .load_req   (load_req)
    );

endmodule

// File: rtl/ipl_source_responder_chk.sv
module ipl_source_responder_chk #(
    parameter int unsigned STATUS_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          role_cfg,
    input logic                init_ipl,
    input logic [STATUS_W-1:0] status_bus,
    input logic                load_done,
    input logic                ipl_tag,
    input logic                load_req
);

    logic init_seen;
    logic qual_edge;

    always_ff @(posedge clk) begin
        init_seen <= init_ipl;
    end

    assign qual_edge = init_ipl && !init_seen &&
                       ((role_cfg == 2'b01 && status_bus[0]) ||
                        (role_cfg == 2'b10 && status_bus[1]));

    // R7: the load request only appears while the tag is up
    a_r7_req_under_tag: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |-> ipl_tag);

    // R7: one cycle after the tag rises the load request is present
    a_r7_req_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ipl_tag) |=> load_req);

    // R6: the tag holds while no completion is reported
    a_r6_tag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ipl_tag && !load_done) |=> ipl_tag);

    // R6: completion during the load releases the tag next cycle
    a_r6_tag_release: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && load_done) |=> !ipl_tag);

    // R4: without a qualified edge an idle tag stays low
    a_r4_no_unqualified: assert property (@(posedge clk) disable iff (!rst_n)
        (!ipl_tag && !qual_edge) |=> !ipl_tag);

    // R5: the illegal role never raises the tag
    a_r5_illegal_role: assert property (@(posedge clk) disable iff (!rst_n)
        (role_cfg == 2'b11 && !ipl_tag) |=> !ipl_tag);

endmodule

bind ipl_source_responder ipl_source_responder_chk #(
    .STATUS_W (STATUS_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .role_cfg   (role_cfg),
    .init_ipl   (init_ipl),
    .status_bus (status_bus),
    .load_done  (load_done),
    .ipl_tag    (ipl_tag),
    .load_req   (load_req)
);

// File: tb/ipl_source_responder_bench.sv
module ipl_source_responder_bench;

    localparam int unsigned STATUS_W = 8;

    typedef struct {
        logic  tag;
        logic  req;
        string rid;
    } exp_item_t;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [1:0]          role_cfg = 2'b00;
    logic                init_ipl = 1'b0;
    logic [STATUS_W-1:0] status_bus = '0;
    logic                load_done = 1'b0;
    logic                ipl_tag;
    logic                load_req;

    exp_item_t sb_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit stim_done = 1'b0;

    always #4 clk = ~clk;

    ipl_source_responder #(.STATUS_W(STATUS_W)) u_ipl_source_responder (
        .clk        (clk),
        .rst_n      (rst_n),
        .role_cfg   (role_cfg),
        .init_ipl   (init_ipl),
        .status_bus (status_bus),
        .load_done  (load_done),
        .ipl_tag    (ipl_tag),
        .load_req   (load_req)
    );

    // Drives one cycle of inputs at the falling edge and queues the outputs
    // expected after the following rising edge. Upper status bits carry noise.
    task automatic drive(input logic rst, input logic [1:0] role, input logic ini,
                         input logic [1:0] sel, input logic dn,
                         input logic et, input logic er, input string rid);
        exp_item_t it;
        @(negedge clk);
        rst_n      = rst;
        role_cfg   = role;
        init_ipl   = ini;
        status_bus = {6'b101101, sel};
        load_done  = dn;
        it.tag = et;
        it.req = er;
        it.rid = rid;
        sb_q.push_back(it);
    endtask

    // Monitor: compares each queued expectation shortly after its clock edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_item_t got;
                got = sb_q.pop_front();
                n_cmp++;
                if (ipl_tag !== got.tag || load_req !== got.req) begin
                    n_bad++;
                    $display("FAIL %s: tag/req actual %b%b expected %b%b",
                             got.rid, ipl_tag, load_req, got.tag, got.req);
                end
            end
        end
    end

    initial begin
        // R1 reset with a qualified edge present
        drive(0, 2'b01, 1, 2'b11, 1, 0, 0, "R1");
        drive(0, 2'b01, 1, 2'b11, 0, 0, 0, "R1");
        // R9 level held across reset release is no edge
        drive(1, 2'b01, 1, 2'b11, 0, 0, 0, "R9");
        drive(1, 2'b01, 1, 2'b11, 0, 0, 0, "R9");
        drive(1, 2'b01, 0, 2'b11, 0, 0, 0, "R9");
        // R2 primary load, R7 request, R6 release
        drive(1, 2'b01, 1, 2'b01, 0, 1, 0, "R2");
        drive(1, 2'b01, 1, 2'b01, 0, 1, 1, "R7");
        drive(1, 2'b01, 0, 2'b00, 0, 1, 1, "R6");
        drive(1, 2'b01, 0, 2'b00, 1, 0, 0, "R6");
        drive(1, 2'b01, 0, 2'b00, 0, 0, 0, "R6");
        // R4 other role's bit, no bit, no role
        drive(1, 2'b01, 1, 2'b10, 0, 0, 0, "R4");
        drive(1, 2'b01, 0, 2'b10, 0, 0, 0, "R4");
        drive(1, 2'b01, 1, 2'b00, 0, 0, 0, "R4");
        drive(1, 2'b01, 0, 2'b00, 0, 0, 0, "R4");
        drive(1, 2'b00, 1, 2'b11, 0, 0, 0, "R4");
        drive(1, 2'b00, 0, 2'b11, 0, 0, 0, "R4");
        // R3 alternate load
        drive(1, 2'b10, 1, 2'b10, 0, 1, 0, "R3");
        drive(1, 2'b10, 1, 2'b10, 0, 1, 1, "R3");
        drive(1, 2'b10, 1, 2'b10, 1, 0, 0, "R6");
        drive(1, 2'b10, 0, 2'b00, 0, 0, 0, "R3");
        drive(1, 2'b10, 1, 2'b01, 0, 0, 0, "R4");
        drive(1, 2'b10, 0, 2'b00, 0, 0, 0, "R4");
        // R5 illegal role
        drive(1, 2'b11, 1, 2'b11, 0, 0, 0, "R5");
        drive(1, 2'b11, 0, 2'b11, 0, 0, 0, "R5");
        drive(1, 2'b11, 1, 2'b11, 0, 0, 0, "R5");
        drive(1, 2'b11, 0, 2'b00, 0, 0, 0, "R5");
        // R8 edges during a running load are ignored
        drive(1, 2'b01, 1, 2'b01, 0, 1, 0, "R2");
        drive(1, 2'b01, 0, 2'b01, 0, 1, 1, "R8");
        drive(1, 2'b01, 1, 2'b01, 0, 1, 1, "R8");
        drive(1, 2'b01, 0, 2'b01, 0, 1, 1, "R8");
        drive(1, 2'b01, 1, 2'b01, 0, 1, 1, "R8");
        drive(1, 2'b01, 1, 2'b01, 1, 0, 0, "R8");
        drive(1, 2'b01, 1, 2'b01, 0, 0, 0, "R8");
        drive(1, 2'b01, 1, 2'b01, 0, 0, 0, "R8");
        drive(1, 2'b01, 0, 2'b01, 0, 0, 0, "R8");
        // R10 completion outside the load
        drive(1, 2'b01, 0, 2'b01, 1, 0, 0, "R10");
        drive(1, 2'b01, 0, 2'b01, 1, 0, 0, "R10");
        drive(1, 2'b01, 1, 2'b01, 0, 1, 0, "R10");
        drive(1, 2'b01, 1, 2'b01, 1, 1, 1, "R10");
        drive(1, 2'b01, 0, 2'b00, 1, 0, 0, "R10");
        drive(1, 2'b01, 0, 2'b00, 0, 0, 0, "R10");
        // R11 edge in DONE ignored, next idle edge accepted
        drive(1, 2'b01, 1, 2'b01, 0, 1, 0, "R11");
        drive(1, 2'b01, 0, 2'b01, 0, 1, 1, "R11");
        drive(1, 2'b01, 0, 2'b01, 1, 0, 0, "R11");
        drive(1, 2'b01, 1, 2'b01, 0, 0, 0, "R11");
        drive(1, 2'b01, 0, 2'b01, 0, 0, 0, "R11");
        drive(1, 2'b01, 1, 2'b01, 0, 1, 0, "R11");
        drive(1, 2'b01, 0, 2'b00, 0, 1, 1, "R11");
        drive(1, 2'b01, 0, 2'b00, 1, 0, 0, "R11");
        drive(1, 2'b01, 0, 2'b00, 0, 0, 0, "R11");
        repeat (3) @(posedge clk);
        stim_done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!stim_done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!stim_done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule